// File: doc/BRIEF.md
# I2C Slave Transmitter with Host Flag Handshake

This block is an I2C bus slave with a 7-bit address. It watches the bus for a start condition and takes in the address frame that follows. When the address matches and the request is a read, it switches into transmit mode without any action from the host. From then on it sends bytes that the host places in a transmit data register, and it signals through an empty flag and an end flag when the host should supply the next byte or close the transfer. A write request is received byte by byte into a receive data register, which raises a full flag.

The host sees four byte-wide registers through a single-cycle read/write port: control, status, transmit data and receive data. On the bus side, SCL and SDA are open-drain. Each has a sampled input and an output-enable that pulls the line low. When the host has not yet supplied a byte, the block holds SCL low. It keeps doing so until the host either writes data or runs the end sequence: clear the transmit-select bit, then make one dummy read of the receive register. The system clock must run at least 8 times the SCL rate.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, both output-enables are 0 and the control (address 0) and status (address 1) registers read 0.
- R2: The address (bits 7..1 of the first byte after a start, MSB first) is compared only in that first byte. A mismatch leaves the block silent until the next start.
- R3: On a match, the block drives the level in control bit 3 (ack level) on SDA for the 9th clock. Value 0 pulls SDA low; value 1 leaves it released.
- R4: When the address byte has bit 0 (read/write) = 1, the block sets control bit 2 (transmit select) and status bit 0 (transmit empty) at the rising edge of the 9th clock.
- R5: Writing address 2 stores a byte and clears transmit empty. At the start of each byte, a pending byte moves to the shift register and transmit empty is set again. Bits go out MSB first, and SDA only changes while SCL is low.
- R6: If transmit empty is 1 when a byte must start, the block holds SCL low until the host writes address 2 or completes the end sequence.
- R7: Status bit 1 (transmit end) is set at the 9th rising edge of a transmitted byte while transmit empty is 1. Writing address 1 with bit 1 = 0 clears it.
- R8: A NACK from the master (SDA high at the 9th clock) stops byte loading and leaves SDA released, without holding SCL.
- R9: After transmit select has been cleared, a read of address 3 made while the block waits in transmit mode releases SCL and returns the block to waiting for an address.
- R10: In a write transfer, each data byte is stored at address 3, status bit 2 (receive full) is set, and the byte is acknowledged with the ack level. Reading address 3 clears receive full.
- R11: A stop or repeated start at any point aborts the transfer, releases both lines and clears transmit select.
- R12: With control bit 0 (enable) = 0, or control bit 1 (master select) = 1, the block leaves the bus alone and acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |

## Verification
Two things can land in the same system clock cycle. One is the host writing the transmit register. The other is the block, at the falling edge of the 9th SCL clock, deciding whether to load the next byte or to start holding SCL. The bench provokes this by sweeping the host write across a range of cycle offsets after the master pulls SCL low on each acknowledge bit, so that some offsets fall before the decision, one falls exactly on it and others fall after it. Every offset is judged by the bytes the master reads back: they must match the written sequence exactly, with none lost or repeated, and the master must be held only until the write arrives.

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx #(
  parameter logic [6:0] SLV_ADDR = 7'h3A,
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);

  localparam logic [CW-1:0] LAST = CW'(8);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_RDAT, S_RACK, S_TDAT, S_TACK, S_TWAIT, S_TEND
  } st_t;

  st_t st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] sh, txd_q, rxd_q;
  logic [CW-1:0] cnt;
  logic en, host_master, tx_sel, ack_lvl;
  logic tx_empty, tx_done, rx_full;
  logic rw_q, nack_q;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_hi   = scl_q[1] & scl_q[2];
  wire start_det = scl_hi & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_hi & ~sda_q[2] & sda_q[1];
  wire active   = en & ~host_master;

  wire wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire wr_stat = reg_wr && reg_addr == 2'd1;
  wire wr_txd  = reg_wr && reg_addr == 2'd2;
  wire rd_rxd  = reg_rd && reg_addr == 2'd3;
  wire end_seq = !tx_sel && rd_rxd;

  assign scl_oe = (st == S_TWAIT);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, ack_lvl, tx_sel, host_master, en};
      2'd1:    reg_rdata = {5'b0, rx_full, tx_done, tx_empty};
      2'd2:    reg_rdata = txd_q;
      default: reg_rdata = rxd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sh <= '0;
      cnt <= '0;
      txd_q <= '0;
      rxd_q <= '0;
      en <= 1'b0;
      host_master <= 1'b0;
      tx_sel <= 1'b0;
      ack_lvl <= 1'b0;
      tx_empty <= 1'b0;
      tx_done <= 1'b0;
      rx_full <= 1'b0;
      rw_q <= 1'b0;
      nack_q <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en <= reg_wdata[0];
        host_master <= reg_wdata[1];
        tx_sel <= reg_wdata[2];
        ack_lvl <= reg_wdata[3];
      end
      if (wr_stat && !reg_wdata[1]) tx_done <= 1'b0;
      if (rd_rxd) rx_full <= 1'b0;
      if (wr_txd) txd_q <= reg_wdata;

      if (!active) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
        tx_sel <= 1'b0;
        tx_empty <= 1'b0;
      end else if (start_det) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
        tx_sel <= 1'b0;
        tx_empty <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 1'b1;
            end
            if (scl_fall && cnt == LAST) begin
              if (sh[7:1] == SLV_ADDR) begin
                st <= S_AACK;
                rw_q <= sh[0];
                sda_oe <= ~ack_lvl;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_rise && rw_q) begin
              tx_sel <= 1'b1;
              tx_empty <= 1'b1;
            end
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt <= '0;
              if (!rw_q) st <= S_RDAT;
              else if (!tx_empty) begin
                sh <= txd_q;
                sda_oe <= ~txd_q[7];
                tx_empty <= 1'b1;
                st <= S_TDAT;
              end else st <= S_TWAIT;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 1'b1;
            end
            if (scl_fall && cnt == LAST) begin
              rxd_q <= sh;
              rx_full <= 1'b1;
              sda_oe <= ~ack_lvl;
              st <= S_RACK;
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt <= '0;
              st <= S_RDAT;
            end
          end
          S_TDAT: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st <= S_TACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              nack_q <= sda_q[1];
              if (tx_empty) tx_done <= 1'b1;
            end
            if (scl_fall) begin
              cnt <= '0;
              if (nack_q) st <= S_TEND;
              else if (!tx_empty) begin
                sh <= txd_q;
                sda_oe <= ~txd_q[7];
                tx_empty <= 1'b1;
                st <= S_TDAT;
              end else st <= S_TWAIT;
            end
          end
          S_TWAIT: begin
            if (end_seq) begin
              st <= S_IDLE;
              tx_empty <= 1'b0;
            end else if (!tx_empty) begin
              sh <= txd_q;
              sda_oe <= ~txd_q[7];
              tx_empty <= 1'b1;
              cnt <= '0;
              st <= S_TDAT;
            end
          end
          S_TEND: begin
            if (end_seq) begin
              st <= S_IDLE;
              tx_empty <= 1'b0;
            end
          end
          default: ;
        endcase
      end

      if (wr_txd) tx_empty <= 1'b0;
    end
  end

  // R6
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !tx_empty) |=> !scl_oe);

  // R5
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q[1]);

  // R7
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tx_empty));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe && !tx_sel));

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_slave_tx_test.sv
module i2c_slave_tx_test;
  localparam logic [6:0] ADR = 7'h3A;
  localparam int H = 10;

  logic clk = 0, rst_n = 0;
  logic m_scl_low = 0, m_sda_low = 0;
  logic scl_oe, sda_oe;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  wire scl_line = !(m_scl_low || scl_oe);
  wire sda_line = !(m_sda_low || sda_oe);
  int nchk = 0, nfail = 0;
  event ev9;

  always #4 clk = ~clk;

  i2c_slave_tx #(.SLV_ADDR(ADR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic hr(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic m_start;
    m_sda_low = 0; m_scl_low = 0; wcyc(H);
    m_sda_low = 1; wcyc(H);
    m_scl_low = 1; wcyc(H);
  endtask

  task automatic m_rstart;
    wcyc(2); m_sda_low = 0; wcyc(H);
    m_scl_low = 0; wait (scl_line); wcyc(H);
    m_sda_low = 1; wcyc(H);
    m_scl_low = 1; wcyc(H);
  endtask

  task automatic m_stop;
    wcyc(2); m_sda_low = 1; wcyc(H);
    m_scl_low = 0; wait (scl_line); wcyc(H);
    m_sda_low = 0; wcyc(H);
  endtask

  task automatic m_bit(input logic b, output logic s);
    wcyc(2);
    m_sda_low = !b; wcyc(H);
    m_scl_low = 0; wait (scl_line); wcyc(H / 2);
    s = sda_line; wcyc(H / 2);
    m_scl_low = 1;
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = !s;
    -> ev9;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, s);
      d = {d[6:0], s};
    end
    m_bit(!give_ack, s);
    -> ev9;
  endtask

  function automatic logic [7:0] pat(int k, int d);
    return 8'(8'hA5 + k * 8'h37 + d * 8'h11);
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    hr(0, v); chk("R1 ctrl", v, 0);
    hr(1, v); chk("R1 stat", v, 0);
  endtask

  task automatic t_write;
    logic a; logic [7:0] v;
    hw(0, 8'h01);
    m_start;
    m_wbyte({ADR, 1'b0}, a); chk("R3 addr ack", a, 1);
    m_wbyte(8'h5A, a); chk("R10 data ack", a, 1);
    hr(1, v); chk("R10 rx_full set", v[2], 1);
    hr(3, v); chk("R10 rx byte", v, 8'h5A);
    hr(1, v); chk("R10 rx_full clear", v[2], 0);
    m_wbyte(8'h96, a);
    hr(3, v); chk("R10 second byte", v, 8'h96);
    m_stop;
    hw(0, 8'h09);
    m_start;
    m_wbyte({ADR, 1'b0}, a); chk("R3 ack level 1 leaves high", a, 0);
    m_stop;
    hw(0, 8'h01);
  endtask

  task automatic t_mismatch;
    logic a; logic [7:0] v;
    m_start;
    m_wbyte(8'h22, a); chk("R2 wrong addr no ack", a, 0);
    m_wbyte({ADR, 1'b0}, a); chk("R2 second frame not compared", a, 0);
    hr(1, v); chk("R2 rx_full untouched", v[2], 0);
    m_stop;
  endtask

  task automatic t_disabled;
    logic a;
    hw(0, 8'h00);
    m_start; m_wbyte({ADR, 1'b0}, a); chk("R12 disabled no ack", a, 0); m_stop;
    hw(0, 8'h03);
    m_start; m_wbyte({ADR, 1'b0}, a); chk("R12 master sel no ack", a, 0); m_stop;
    hw(0, 8'h01);
  endtask

  task automatic t_stretch;
    logic a; logic [7:0] v, b;
    m_start;
    m_wbyte({ADR, 1'b1}, a); chk("R3 read addr ack", a, 1);
    wcyc(6);
    hr(0, v); chk("R4 tx_sel set", v[2], 1);
    hr(1, v); chk("R4 tx_empty set", v[0], 1);
    chk("R6 holding scl", scl_oe, 1);
    fork
      m_rbyte(1'b1, b);
      begin
        wcyc(30);
        chk("R6 still holding", scl_oe, 1);
        hw(2, 8'hC3);
      end
    join
    chk("R5 byte msb first", b, 8'hC3);
    wcyc(6);
    chk("R6 hold after acked last byte", scl_oe, 1);
    hr(1, v); chk("R7 tx_done set", v[1], 1);
    hw(1, 8'h00);
    hr(1, v); chk("R7 tx_done cleared", v[1], 0);
    hw(0, 8'h01);
    wcyc(4);
    chk("R9 hold until dummy read", scl_oe, 1);
    hr(3, v);
    wcyc(2);
    chk("R9 released", scl_oe, 0);
    m_stop;
  endtask

  task automatic t_burst(int d);
    logic a; logic [7:0] v, b;
    m_start;
    fork
      begin
        m_wbyte({ADR, 1'b1}, a);
        chk("R4 burst addr ack", a, 1);
        for (int k = 0; k < 3; k++) begin
          m_rbyte(k < 2, b);
          chk($sformatf("R5 burst byte %0d offset %0d", k, d), b, pat(k, d));
        end
      end
      for (int k = 0; k < 3; k++) begin
        @(ev9);
        wcyc(d);
        hw(2, pat(k, d));
      end
    join
    wcyc(4);
    chk("R8 nack releases sda", sda_oe, 0);
    chk("R8 nack no hold", scl_oe, 0);
    hr(1, v); chk("R7 tx_done after last", v[1], 1);
    hw(1, 8'h00);
    hw(0, 8'h01);
    hr(3, v);
    m_stop;
    hr(0, v); chk("R11 tx_sel clear after stop", v[2], 0);
  endtask

  task automatic t_rstart;
    logic a; logic [7:0] v, b;
    logic s;
    m_start;
    fork
      begin
        m_wbyte({ADR, 1'b1}, a);
        for (int i = 0; i < 4; i++) begin
          m_bit(1'b1, s);
          b = {b[6:0], s};
        end
      end
      begin
        @(ev9);
        wcyc(8);
        hw(2, 8'hFF);
      end
    join
    m_rstart;
    hr(0, v); chk("R11 repeated start clears tx_sel", v[2], 0);
    chk("R11 sda released", sda_oe, 0);
    m_wbyte({ADR, 1'b0}, a); chk("R11 new addr ack", a, 1);
    m_wbyte(8'h3C, a);
    hr(3, v); chk("R11 receive after abort", v, 8'h3C);
    m_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wcyc(3);
    rst_n = 1;
    wcyc(3);
    t_reset;
    t_write;
    t_mismatch;
    t_disabled;
    t_stretch;
    for (int d = 0; d < 7; d++) t_burst(d);
    t_rstart;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule